// File: doc/BRIEF.md
# Trace Port Configuration Controller

This block sits between an on-chip source of trace words and the pins of a parallel debug trace output port. Only a debug tool, through a small register write interface, configures it. The configuration selects the trace clock ratio, the port width (12 or 16 data pins), and whether the trace clock stops while nothing is being sent. A separate bit turns the port on. Trace words arrive with a valid/ready handshake and leave as beats. Each beat is launched on a falling edge of the trace clock and marked on a two-pin start/end code, so the tool samples it on the rising edge.

The block clock `clk` runs at twice the system clock rate. The trace clock therefore lasts 2*N `clk` cycles for a system-clock ratio of N.

From reset until a clock-lock input is seen, the lowest data pin is held high as a status indication, and tool writes are refused. Each time the port is switched on, a single-beat identification word is sent ahead of any trace traffic. While the narrow width is selected, the upper four data pins are released to their general purpose function.

Top module: `trace_port_ctrl`

## Requirements
- R1: After reset the configuration reads 8'h00, the trace clock is low, the mark pins show the idle code 2'b11 and no word is accepted.
- R2: From reset until `lock_i` is seen high, `mdo_o[0]` is held at 1 and tool writes have no effect. The cycle after lock the status drops, and from then on writes are taken.
- R3: The configuration layout is {spare[7:6], ratio[5:3], gate[2], wide[1], en[0]}. Ratio codes 3'b000, 3'b001, 3'b011 and 3'b111 give trace clock periods of 2, 4, 8 and 16 `clk` cycles.
- R4: A write with any other ratio code keeps the stored ratio and still applies the write's other fields.
- R5: While en is 1 the ratio field cannot change. A write that attempts it leaves both the stored value and the clock period as they were.
- R6: With wide=1 all 16 data pins carry the word and `upper_trace_o` is 1. With wide=0, `mdo_o[15:12]` are 0 and `upper_trace_o` is 0.
- R7: When en goes from 0 to 1, the word ID_WORD is sent exactly once, as a single beat with the end code 2'b01, before any trace word.
- R8: Data and mark pins change only at a falling edge of the trace clock. A beat that is not last carries mark 2'b00 and a last beat carries 2'b01. A word is accepted only in the cycle just before such an edge.
- R9: With gate=1 the trace clock stops low when nothing is pending. It restarts at least one full trace clock period before the first beat, and stops only after the end beat has been followed by an idle edge.
- R10: With gate=0 and en=1 the trace clock runs without a break.
- R11: The spare bits [7:6] read back as written and change neither the clock nor the data.
- R12: With en=0 the trace clock stays low, the mark pins stay idle and no word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the system clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Clock-stable indication that ends the status phase |
| cfg_wr_i | input | 1 | Tool-side configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Current configuration |
| msg_valid_i | input | 1 | A trace word is offered |
| msg_data_i | input | 16 | Trace word |
| msg_last_i | input | 1 | Offered word ends its message |
| msg_ready_o | output | 1 | Offered word is taken at this clock edge |
| mcko_o | output | 1 | Trace clock |
| mdo_o | output | 16 | Trace data pins |
| mseo_o | output | 2 | Start/end mark pins |
| upper_trace_o | output | 1 | 1: pins 15:12 serve the trace port; 0: they return to general purpose use |

## Verification
A wrong stored ratio shows at once as a trace clock period that differs from the table for the written code. A broken warm-up or gate state shows as a beat launched less than one period after a restart, or as a clock that keeps toggling while idle. A lost or repeated identification request appears at the first beats after an enable, as a missing ID_WORD or an extra one. Status or write-lock errors show on `mdo_o[0]` and on the read-back configuration within two cycles of the lock edge.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    // Tool-visible configuration layout, least significant field last.
    typedef struct packed {
        logic [1:0] spare;
        logic [2:0] ratio;
        logic       gate;
        logic       wide;
        logic       en;
    } tpc_cfg_t;

    localparam int CFG_W  = $bits(tpc_cfg_t);
    localparam int HALF_W = 4;

    typedef enum logic [1:0] {
        MK_BODY = 2'b00,
        MK_END  = 2'b01,
        MK_IDLE = 2'b11
    } tpc_mark_e;

    // Ratio codes are thermometer coded; everything else is refused.
    function automatic logic ratio_ok(input logic [2:0] code);
        return (code == 3'b000) || (code == 3'b001) ||
               (code == 3'b011) || (code == 3'b111);
    endfunction

    // Number of clk cycles in each trace clock phase.
    function automatic logic [HALF_W-1:0] ratio_half(input logic [2:0] code);
        return 4'd1 + {3'd0, code[0]} + {2'd0, code[1], 1'b0} + {1'b0, code[2], 2'b00};
    endfunction

endpackage

// File: rtl/tpc_cfg.sv
module tpc_cfg
    import tpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_i,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    output tpc_cfg_t         cfg_o,
    output logic             status_o,
    output logic             en_rise_o
);

    typedef struct packed {
        tpc_cfg_t cfg;
        logic     status;
    } cfg_state_t;

    cfg_state_t s_d, s_q;
    tpc_cfg_t   w;

    always_comb begin
        w         = tpc_cfg_t'(wdata_i);
        s_d       = s_q;
        en_rise_o = 1'b0;
        if (s_q.status) begin
            // Status phase: writes are refused until the clock is stable.
            if (lock_i) begin
                s_d.status = 1'b0;
            end
        end else if (wr_i) begin
            s_d.cfg.en    = w.en;
            s_d.cfg.wide  = w.wide;
            s_d.cfg.gate  = w.gate;
            s_d.cfg.spare = w.spare;
            // Ratio is frozen while the port runs; unknown codes are dropped.
            if (!s_q.cfg.en && ratio_ok(w.ratio)) begin
                s_d.cfg.ratio = w.ratio;
            end
            en_rise_o = w.en && !s_q.cfg.en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cfg    <= '0;
            s_q.status <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o    = s_q.cfg;
    assign status_o = s_q.status;

endmodule

// File: rtl/tpc_clkgen.sv
module tpc_clkgen
    import tpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       gate_i,
    input  logic [2:0] ratio_i,
    input  logic       need_i,
    output logic       mcko_o,
    output logic       fall_o,
    output logic       warm_o
);

    localparam int CNT_W = HALF_W;

    typedef struct packed {
        logic             run;
        logic             warm;
        logic             mck;
        logic [CNT_W-1:0] cnt;
    } clk_state_t;

    clk_state_t       s_d, s_q;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] wrap_at;

    always_comb begin
        half    = ratio_half(ratio_i);
        wrap_at = {half[CNT_W-2:0], 1'b0} - 1'b1;
        s_d     = s_q;
        if (!en_i) begin
            s_d.run  = 1'b0;
            s_d.warm = 1'b0;
            s_d.cnt  = '0;
        end else if (!s_q.run) begin
            if (need_i) begin
                s_d.run  = 1'b1;
                s_d.warm = 1'b0;
                s_d.cnt  = '0;
            end
        end else if (s_q.cnt == wrap_at) begin
            s_d.cnt = '0;
            // Stop only at the end of a low phase, and only when nothing waits.
            if (gate_i && !need_i) begin
                s_d.run  = 1'b0;
                s_d.warm = 1'b0;
            end else begin
                s_d.warm = 1'b1;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        s_d.mck = s_d.run && (s_d.cnt < half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mcko_o = s_q.mck;
    assign fall_o = s_q.run && (s_q.cnt == half - 1'b1);
    assign warm_o = s_q.warm;

endmodule

// File: rtl/tpc_beat.sv
module tpc_beat
    import tpc_pkg::*;
#(
    parameter int                 DATA_W   = 16,
    parameter int                 NARROW_W = 12,
    parameter logic [DATA_W-1:0]  ID_WORD  = 16'hC35A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wide_i,
    input  logic              en_rise_i,
    input  logic              fall_i,
    input  logic              warm_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              last_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] mdo_o,
    output logic [1:0]        mark_o,
    output logic              pending_o,
    output logic              busy_o
);

    localparam int                UPPER_W     = DATA_W - NARROW_W;
    localparam logic [DATA_W-1:0] NARROW_MASK = {{UPPER_W{1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0] mdo;
        tpc_mark_e         mark;
        logic              id_pend;
    } beat_state_t;

    beat_state_t s_d, s_q;
    logic        take;

    always_comb begin
        s_d  = s_q;
        take = en_i && fall_i && warm_i && !s_q.id_pend;
        if (!en_i) begin
            s_d.mdo     = '0;
            s_d.mark    = MK_IDLE;
            s_d.id_pend = en_rise_i;
        end else if (fall_i) begin
            if (warm_i && s_q.id_pend) begin
                s_d.mdo     = ID_WORD;
                s_d.mark    = MK_END;
                s_d.id_pend = 1'b0;
            end else if (take && valid_i) begin
                s_d.mdo  = data_i;
                s_d.mark = last_i ? MK_END : MK_BODY;
            end else begin
                s_d.mdo  = '0;
                s_d.mark = MK_IDLE;
            end
        end
        if (!wide_i) begin
            s_d.mdo = s_d.mdo & NARROW_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mdo     <= '0;
            s_q.mark    <= MK_IDLE;
            s_q.id_pend <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o   = take;
    assign mdo_o     = s_q.mdo;
    assign mark_o    = s_q.mark;
    assign pending_o = s_q.id_pend || valid_i;
    assign busy_o    = (s_q.mark != MK_IDLE);

endmodule

// File: rtl/trace_port_ctrl.sv
module trace_port_ctrl
    import tpc_pkg::*;
#(
    parameter int                DATA_W   = 16,
    parameter int                NARROW_W = 12,
    parameter logic [DATA_W-1:0] ID_WORD  = 16'hC35A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              cfg_wr_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    output logic [CFG_W-1:0]  cfg_rdata_o,
    input  logic              msg_valid_i,
    input  logic [DATA_W-1:0] msg_data_i,
    input  logic              msg_last_i,
    output logic              msg_ready_o,
    output logic              mcko_o,
    output logic [DATA_W-1:0] mdo_o,
    output logic [1:0]        mseo_o,
    output logic              upper_trace_o
);

    tpc_cfg_t          cfg_w;
    logic              status_w;
    logic              en_rise_w;
    logic              en_w;
    logic              wide_w;
    logic              fall_w;
    logic              warm_w;
    logic              pending_w;
    logic              busy_w;
    logic              need_w;
    logic [DATA_W-1:0] beat_w;

    tpc_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_i    (lock_i),
        .wr_i      (cfg_wr_i),
        .wdata_i   (cfg_wdata_i),
        .cfg_o     (cfg_w),
        .status_o  (status_w),
        .en_rise_o (en_rise_w)
    );

    assign en_w   = cfg_w.en;
    assign wide_w = cfg_w.wide;
    assign need_w = !cfg_w.gate || pending_w || busy_w;

    tpc_clkgen u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_w),
        .gate_i  (cfg_w.gate),
        .ratio_i (cfg_w.ratio),
        .need_i  (need_w),
        .mcko_o  (mcko_o),
        .fall_o  (fall_w),
        .warm_o  (warm_w)
    );

    tpc_beat #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .ID_WORD  (ID_WORD)
    ) u_beat (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_w),
        .wide_i    (wide_w),
        .en_rise_i (en_rise_w),
        .fall_i    (fall_w),
        .warm_i    (warm_w),
        .valid_i   (msg_valid_i),
        .data_i    (msg_data_i),
        .last_i    (msg_last_i),
        .ready_o   (msg_ready_o),
        .mdo_o     (beat_w),
        .mark_o    (mseo_o),
        .pending_o (pending_w),
        .busy_o    (busy_w)
    );

    // Status indication overrides the lowest data pin until lock.
    assign mdo_o         = {beat_w[DATA_W-1:1], beat_w[0] | status_w};
    assign cfg_rdata_o   = cfg_w;
    assign upper_trace_o = en_w && wide_w;

endmodule

// File: rtl/tpc_checker.sv
module tpc_checker
    import tpc_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              status_i,
    input logic              en_i,
    input logic              wide_i,
    input logic              mcko_i,
    input logic [1:0]        mseo_i,
    input logic [DATA_W-1:0] mdo_i,
    input logic              ready_i,
    input logic [CFG_W-1:0]  cfg_i
);

    p_status_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_i |-> mdo_i[0]);

    p_status_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_i |=> $stable(cfg_i));

    p_upper_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_i && $past(!wide_i)) |-> (mdo_i[DATA_W-1:NARROW_W] == '0));

    p_mark_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && !$stable(mseo_i)) |-> $fell(mcko_i));

    p_accept_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready_i |=> $fell(mcko_i));

    p_off_no_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !ready_i);

    p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!mcko_i && mseo_i == 2'b11));

endmodule

bind trace_port_ctrl tpc_checker #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_w),
    .en_i     (en_w),
    .wide_i   (wide_w),
    .mcko_i   (mcko_o),
    .mseo_i   (mseo_o),
    .mdo_i    (mdo_o),
    .ready_i  (msg_ready_o),
    .cfg_i    (cfg_rdata_o)
);

// File: tb/trace_port_ctrl_tb.sv
module trace_port_ctrl_tb;

    localparam logic [15:0] IDW = 16'hC35A;

    logic        clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        lock = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        msg_valid = 1'b0;
    logic [15:0] msg_data = 16'h0000;
    logic        msg_last = 1'b0;
    logic        msg_ready;
    logic        mcko;
    logic [15:0] mdo;
    logic [1:0]  mseo;
    logic        upper;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    trace_port_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .lock_i        (lock),
        .cfg_wr_i      (cfg_wr),
        .cfg_wdata_i   (cfg_wdata),
        .cfg_rdata_o   (cfg_rdata),
        .msg_valid_i   (msg_valid),
        .msg_data_i    (msg_data),
        .msg_last_i    (msg_last),
        .msg_ready_o   (msg_ready),
        .mcko_o        (mcko),
        .mdo_o         (mdo),
        .mseo_o        (mseo),
        .upper_trace_o (upper)
    );

    // Port monitor: samples 1 ns after each rising edge.
    int          cyc = 0;
    logic        prev_mck = 1'b0;
    int          rise_cnt = 0;
    int          last_rise = 0;
    int          prev_rise = 0;
    bit          arm = 1'b0;
    int          rise_mark = 0;
    int          nb = 0;
    logic [1:0]  b_mk  [64];
    logic [15:0] b_dat [64];
    int          b_cyc [64];

    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        if (!prev_mck && mcko) begin
            rise_cnt  = rise_cnt + 1;
            prev_rise = last_rise;
            last_rise = cyc;
            if (arm) begin
                rise_mark = cyc;
                arm = 1'b0;
            end
        end
        if (prev_mck && !mcko && mseo != 2'b11) begin
            if (nb < 64) begin
                b_mk[nb]  = mseo;
                b_dat[nb] = mdo;
                b_cyc[nb] = cyc;
            end
            nb = nb + 1;
        end
        prev_mck = mcko;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input logic [1:0] sp, input logic [2:0] ra,
                                      input logic ga, input logic wi, input logic en);
        return {sp, ra, ga, wi, en};
    endfunction

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic period(output int p);
        int r0;
        r0 = rise_cnt;
        while (rise_cnt < r0 + 3) @(negedge clk);
        p = last_rise - prev_rise;
    endtask

    task automatic send(input logic [15:0] d, input logic l);
        msg_valid = 1'b1;
        msg_data  = d;
        msg_last  = l;
        while (!msg_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {ratio code, accepted, expected period in clk cycles}
    localparam logic [11:0] VEC [7] = '{
        {3'b000, 1'b1, 8'd2},
        {3'b001, 1'b1, 8'd4},
        {3'b010, 1'b0, 8'd4},
        {3'b011, 1'b1, 8'd8},
        {3'b101, 1'b0, 8'd8},
        {3'b111, 1'b1, 8'd16},
        {3'b000, 1'b1, 8'd2}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] cur;
        int         p;
        int         r;
        bit         quiet;

        idle(5);
        rst_n = 1'b1;
        idle(3);

        // R1 reset state
        check("R1 cfg after reset", 32'(cfg_rdata), 32'h00);
        check("R1 trace clock low", 32'(mcko), 32'h0);
        check("R1 mark idle", 32'(mseo), 32'h3);
        check("R1 nothing accepted", 32'(msg_ready), 32'h0);

        // R2 status phase
        check("R2 status pin high before lock", 32'(mdo[0]), 32'h1);
        wr(8'hFF);
        check("R2 write refused before lock", 32'(cfg_rdata), 32'h00);
        check("R2 status pin still high", 32'(mdo[0]), 32'h1);
        lock = 1'b1;
        idle(2);
        check("R2 status pin low after lock", 32'(mdo[0]), 32'h0);
        wr(mk(2'b00, 3'b000, 1'b0, 1'b1, 1'b0));
        check("R2 write taken after lock", 32'(cfg_rdata), 32'h02);

        // R3 / R4 / R10 ratio table, free-running clock
        cur = 3'b000;
        for (int i = 0; i < 7; i++) begin
            wr(mk(2'b00, VEC[i][11:9], 1'b0, 1'b1, 1'b0));
            if (VEC[i][8]) cur = VEC[i][11:9];
            check("R4 stored ratio after write", 32'(cfg_rdata[5:3]), 32'(cur));
            wr(mk(2'b00, VEC[i][11:9], 1'b0, 1'b1, 1'b1));
            period(p);
            check("R3 R10 trace clock period", 32'(p), 32'(VEC[i][7:0]));
            wr(mk(2'b00, cur, 1'b0, 1'b1, 1'b0));
        end

        // R5 ratio frozen while enabled
        wr(mk(2'b00, 3'b001, 1'b0, 1'b1, 1'b0));
        wr(mk(2'b00, 3'b001, 1'b0, 1'b1, 1'b1));
        wr(mk(2'b00, 3'b111, 1'b0, 1'b1, 1'b1));
        check("R5 ratio unchanged while enabled", 32'(cfg_rdata[5:3]), 32'h1);
        period(p);
        check("R5 period unchanged while enabled", 32'(p), 32'd4);

        // R12 disabled port is quiet
        wr(mk(2'b00, 3'b000, 1'b0, 1'b1, 1'b0));
        idle(2);
        quiet = 1'b1;
        for (int k = 0; k < 12; k++) begin
            if (mcko !== 1'b0 || mseo !== 2'b11 || msg_ready !== 1'b0) quiet = 1'b0;
            @(negedge clk);
        end
        check("R12 quiet while disabled", 32'(quiet), 32'h1);

        // R7 R8 R6 identification then a three-beat message, wide port
        wr(mk(2'b00, 3'b000, 1'b0, 1'b1, 1'b0));
        nb = 0;
        wr(mk(2'b00, 3'b000, 1'b0, 1'b1, 1'b1));
        send(16'hFFFF, 1'b0);
        send(16'h1234, 1'b0);
        send(16'hABCD, 1'b1);
        msg_valid = 1'b0;
        idle(20);
        check("R7 beat count id plus message", 32'(nb), 32'd4);
        check("R7 id beat mark", 32'(b_mk[0]), 32'h1);
        check("R7 id beat data", 32'(b_dat[0]), 32'(IDW));
        check("R8 body mark", 32'(b_mk[1]), 32'h0);
        check("R6 wide data all pins", 32'(b_dat[1]), 32'hFFFF);
        check("R8 second body", {14'd0, b_mk[2], b_dat[2]}, {14'd0, 2'b00, 16'h1234});
        check("R8 end beat", {14'd0, b_mk[3], b_dat[3]}, {14'd0, 2'b01, 16'hABCD});
        check("R6 upper pins owned when wide", 32'(upper), 32'h1);

        // R6 narrow port
        wr(mk(2'b00, 3'b000, 1'b0, 1'b0, 1'b0));
        nb = 0;
        wr(mk(2'b00, 3'b000, 1'b0, 1'b0, 1'b1));
        send(16'hFFFF, 1'b1);
        msg_valid = 1'b0;
        idle(20);
        check("R6 narrow beat count", 32'(nb), 32'd2);
        check("R6 narrow id masked", 32'(b_dat[0]), 32'(IDW & 16'h0FFF));
        check("R6 narrow data masked", 32'(b_dat[1]), 32'h0FFF);
        check("R6 upper pins released", 32'(upper), 32'h0);

        // R11 spare bits read back, no effect
        wr(mk(2'b11, 3'b000, 1'b0, 1'b0, 1'b1));
        check("R11 spare read back", 32'(cfg_rdata), 32'hC1);
        period(p);
        check("R11 period unaffected", 32'(p), 32'd2);
        check("R11 width unaffected", 32'(upper), 32'h0);

        // R9 gated clock
        wr(mk(2'b00, 3'b000, 1'b0, 1'b1, 1'b0));
        wr(mk(2'b00, 3'b001, 1'b1, 1'b1, 1'b0));
        nb = 0;
        wr(mk(2'b00, 3'b001, 1'b1, 1'b1, 1'b1));
        idle(40);
        check("R9 id sent with gating", 32'(nb), 32'd1);
        r = rise_cnt;
        idle(30);
        check("R9 clock stopped when idle", 32'(rise_cnt - r), 32'd0);
        check("R9 clock parked low", 32'(mcko), 32'h0);
        arm = 1'b1;
        send(16'h0F0F, 1'b1);
        msg_valid = 1'b0;
        idle(30);
        check("R9 gated beat count", 32'(nb), 32'd2);
        check("R9 gated end beat", {14'd0, b_mk[1], b_dat[1]}, {14'd0, 2'b01, 16'h0F0F});
        check("R9 restart at least one period early", 32'(b_cyc[1] - rise_mark >= 4), 32'h1);
        r = rise_cnt;
        idle(30);
        check("R9 clock stops after end beat", 32'(rise_cnt - r), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule